// File: doc/BRIEF.md
# Sequential Trigger Delay Generator

This block turns a logic-level gate into a delayed output pulse of fixed length. A rising edge on the asynchronous input starts a delay timer. When that timer runs out, a second timing phase drives the output high for a programmed number of cycles. Then the block returns to idle. The input is used only as a trigger. Its falling edge does nothing, and the output width does not depend on how long the input stayed high.

The input first passes through a synchroniser and a rising-edge detector. The delay count and the pulse-length count are sampled when a trigger is accepted, so software or a neighbouring block may change them freely while a sequence is running. Triggers that arrive while a sequence is running are dropped. This applies to both the delay phase and the output phase, so a running sequence can be neither restarted nor extended.

Top module: `trig_delay_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) forces pulse_out and busy low from that edge on and returns the block to idle.
- R2: With the block idle, gate_in going high ahead of clock edge 1 makes busy rise at clock edge 3. This accounts for two synchroniser stages plus one register for acceptance.
- R3: pulse_out rises delay_cnt + 1 clock cycles after busy rises, that is at edge 4 + delay_cnt.
- R4: pulse_out stays high for width_cnt + 1 cycles. pulse_out and busy then fall together at edge 5 + delay_cnt + width_cnt.
- R5: A count of zero gives a phase of exactly one cycle, for both the delay and the pulse length.
- R6: A falling edge of gate_in has no effect at any time. The output timing is the same whether gate_in is held for one cycle or for longer than the whole sequence.
- R7: A rising edge of gate_in during the delay phase is ignored and does not restart the delay.
- R8: A rising edge of gate_in during the output phase is ignored and does not lengthen the pulse. Once the block is idle again, a new rising edge is accepted with the R2 timing.
- R9: delay_cnt and width_cnt are captured when a trigger is accepted. Changing either one afterwards has no effect on the sequence in progress.
- R10: pulse_out is high only while busy is high. busy is high through both the delay phase and the output phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_in | input | 1 | Asynchronous trigger input; only its rising edge counts |
| delay_cnt | input | 16 | Delay phase length minus one, in clock cycles |
| width_cnt | input | 16 | Output pulse length minus one, in clock cycles |
| pulse_out | output | 1 | Delayed fixed-width output pulse |
| busy | output | 1 | High during the delay phase and the output phase |

## Verification
Both outputs are decoded directly from the state register. A wrong state therefore shows at pulse_out or busy in the same cycle it arises. A timer that was reloaded or restarted by a stray trigger shows up as an edge that moves by a whole number of cycles, and the bench checks every cycle of each sequence against the edge numbers given in R2 to R4. A count captured at the wrong moment also moves those edges, because the inputs change in the middle of a sequence.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_GATE  = 2'd2
   } tdg_state_e;
endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tdg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];
endmodule

// File: rtl/tdg_rise.sv
module tdg_rise (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic rise
);
   logic level_d;

   always_ff @(posedge clk) begin
      if (rst) level_d <= 1'b0;
      else     level_d <= level;
   end

   assign rise = level & ~level_d;
endmodule

// File: rtl/tdg_timer.sv
module tdg_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);
   always_ff @(posedge clk) begin
      if (rst)            cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen
   import tdg_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             gate_in,
   input  logic [CNT_W-1:0] delay_cnt,
   input  logic [CNT_W-1:0] width_cnt,
   output logic             pulse_out,
   output logic             busy
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("trig_delay_gen: CNT_W must lie in 1..32");
      end
   endgenerate

   logic             gate_s;
   logic             rise;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic [CNT_W-1:0] tmr_cnt;
   logic             tmr_zero;
   logic [CNT_W-1:0] width_q;
   tdg_state_e       state_q;
   tdg_state_e       state_d;

   tdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst (rst), .d (gate_in), .q (gate_s)
   );

   tdg_rise u_rise (
      .clk (clk), .rst (rst), .level (gate_s), .rise (rise)
   );

   tdg_timer #(.CNT_W(CNT_W)) u_timer (
      .clk (clk), .rst (rst), .load (tmr_load), .load_val (tmr_val),
      .cnt (tmr_cnt), .zero (tmr_zero)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = delay_cnt;
      unique case (state_q)
         ST_IDLE: begin
            if (rise) begin
               state_d  = ST_DELAY;
               tmr_load = 1'b1;
               tmr_val  = delay_cnt;
            end
         end
         ST_DELAY: begin
            if (tmr_zero) begin
               state_d  = ST_GATE;
               tmr_load = 1'b1;
               tmr_val  = width_q;
            end
         end
         ST_GATE: begin
            if (tmr_zero) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         width_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && rise) width_q <= width_cnt;
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign pulse_out = (state_q == ST_GATE);
endmodule

// File: rtl/tdg_checker.sv
module tdg_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             pulse_out,
   input logic             busy,
   input logic             rise,
   input logic [1:0]       state_q,
   input logic [CNT_W-1:0] tmr_cnt
);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (!busy && !pulse_out));

   // R10
   pulse_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
      pulse_out |-> busy);

   // R7
   delay_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == 2'd1 && tmr_cnt != '0) |=>
         (state_q == 2'd1 && tmr_cnt == $past(tmr_cnt) - 1'b1));

   // R8
   gate_no_extend_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == 2'd2 && tmr_cnt != '0) |=>
         (state_q == 2'd2 && tmr_cnt == $past(tmr_cnt) - 1'b1));

   // R3
   gate_after_delay_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_out) |-> $past(busy));

   // R4
   end_together_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(pulse_out) |-> !busy);

   // R2
   accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == 2'd0 && rise) |=> (busy && !pulse_out));

   // R10
   state_legal_chk: assert property (@(posedge clk) disable iff (rst)
      state_q != 2'd3);
endmodule

bind trig_delay_gen tdg_checker #(.CNT_W(CNT_W)) u_tdg_chk (
   .clk (clk), .rst (rst), .pulse_out (pulse_out), .busy (busy),
   .rise (rise), .state_q (state_q), .tmr_cnt (tmr_cnt)
);

// File: tb/test_trig_delay_gen.sv
`timescale 1ns/1ps
module test_trig_delay_gen;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        gate_in = 1'b0;
   logic [15:0] delay_cnt = '0;
   logic [15:0] width_cnt = '0;
   logic        pulse_out;
   logic        busy;
   int          n_checks = 0;
   int          n_fail = 0;

   always #5 clk = ~clk;

   trig_delay_gen i_trig_delay_gen (
      .clk (clk), .rst (rst), .gate_in (gate_in), .delay_cnt (delay_cnt),
      .width_cnt (width_cnt), .pulse_out (pulse_out), .busy (busy)
   );

   task automatic check(string tag, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Drives one trigger and checks both outputs after every clock edge.
   // n counts the rising edges after gate_in goes high. The bench expects
   // busy for n in [3, 5+D+W) and pulse_out for n in [4+D, 5+D+W).
   task automatic run_seq(string tag, int d, int w, int hold, int rtg, int chg);
      @(negedge clk);
      delay_cnt = 16'(d);
      width_cnt = 16'(w);
      gate_in   = 1'b1;
      for (int n = 1; n <= d + w + 8; n++) begin
         @(negedge clk);
         check(tag, "busy", busy, (n >= 3 && n < 5 + d + w));
         check(tag, "pulse_out", pulse_out, (n >= 4 + d && n < 5 + d + w));
         if (n == hold) gate_in = 1'b0;
         if (n == rtg)  gate_in = 1'b1;
         if (n == chg) begin
            delay_cnt = 16'd0;
            width_cnt = 16'd0;
         end
      end
      gate_in = 1'b0;
      repeat (4) @(negedge clk);
      check(tag, "idle busy", busy, 1'b0);
      check(tag, "idle pulse_out", pulse_out, 1'b0);
   endtask

   task automatic t_reset_state();
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", busy, 1'b0);
      check("R1", "pulse_out in reset", pulse_out, 1'b0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "busy after reset", busy, 1'b0);
   endtask

   task automatic t_basic();     run_seq("R3 R4 R2", 5, 3, 20, 0, 0);  endtask
   task automatic t_short_in();  run_seq("R6", 5, 3, 1, 0, 0);        endtask
   task automatic t_zero();      run_seq("R5", 0, 0, 2, 0, 0);        endtask
   task automatic t_rtg_delay(); run_seq("R7", 10, 5, 2, 6, 0);       endtask
   task automatic t_rtg_gate();  run_seq("R8", 2, 12, 3, 8, 0);       endtask
   task automatic t_rearm();     run_seq("R8 rearm", 1, 1, 1, 0, 0);  endtask
   task automatic t_latch();     run_seq("R9", 8, 6, 2, 0, 5);        endtask
   task automatic t_long();      run_seq("R3 long", 300, 200, 2, 0, 0); endtask

   task automatic t_reset_mid();
      @(negedge clk);
      delay_cnt = 16'd20;
      width_cnt = 16'd4;
      gate_in   = 1'b1;
      repeat (10) @(negedge clk);
      check("R1", "busy before reset", busy, 1'b1);
      gate_in = 1'b0;
      rst     = 1'b1;
      @(negedge clk);
      check("R1", "busy after mid reset", busy, 1'b0);
      check("R1", "pulse_out after mid reset", pulse_out, 1'b0);
      rst = 1'b0;
      repeat (30) @(negedge clk);
      check("R1", "stays idle", busy | pulse_out, 1'b0);
   endtask

   initial begin
      t_reset_state();
      t_basic();
      t_short_in();
      t_zero();
      t_rtg_delay();
      t_rtg_gate();
      t_rearm();
      t_latch();
      t_long();
      t_reset_mid();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule